// File: doc/BRIEF.md
# Split-Port Four-Word Burst Memory

This block is a synchronous on-chip memory with one port that only reads and another that only writes, so read data and write data never share wires and no bus turnaround is needed. Every access moves exactly four words. The words travel at double data rate: one per edge of a slow "main" clock, which gives four words in two main-clock periods. To stay synthesizable, both edges of the main clock are represented by one fast clock at twice the main rate. An internal phase flag marks each fast cycle as a rise slot or a fall slot, and the block shows that flag on `main_rise`.

A read request is made with an active-low select in a rise slot. A write request is made with its own active-low select in a fall slot. Both use one shared address bus, so the two requests sit in different slots of the same main cycle. The storage is four parallel banks, one for each word position in a burst. All four banks share the row given by the address. Each write word carries active-low byte-lane strobes for 9-bit lanes.

Read data leaves as a valid-only stream on `rd_valid`/`rd_data`. There is no ready signal, so the consumer must take a word in every cycle that `rd_valid` is high; back-pressure is not possible. Write data has no handshake either. The four words must be on `wr_data` in the four fast cycles that follow the write request slot.

Top module: `burst4_sram`

## Requirements
- R1: While reset is held, `rd_valid` and `rd_data` are 0 and `main_rise` is 1. In the first cycle after the first clock edge with reset released, `main_rise` is 0, and after that it alternates every cycle.
- R2: `rd_sel_n` low in a rise slot (cycle A) starts a read of row `addr`. Words from banks 0, 1, 2 and 3 of that row appear on `rd_data` in cycles A+3 to A+6, with `rd_valid` high in each of those cycles.
- R3: A read request in the rise slot directly after an accepted read request is ignored, because an accepted burst cannot be cut short. The rise slot after that is accepted, and its burst follows the earlier one without a gap.
- R4: `wr_sel_n` low in a fall slot (cycle B) starts a write to row `addr`. The `wr_data` values in cycles B+1 to B+4 are stored into banks 0 to 3 of that row.
- R5: A write request in the fall slot directly after an accepted write request is ignored and leaves the memory unchanged.
- R6: Bit l of `wr_be_n` set low stores `wr_data[9l+8:9l]` of that word. Bit l set high keeps the stored lane.
- R7: A read and a write may overlap in time. A read returns the data of every accepted write whose request slot came before the read's request slot, and does not return data from later writes.
- R8: `rd_data` holds its value in every cycle where `rd_valid` is low, and `rd_valid` is high in runs that are whole multiples of four cycles.
- R9: `rd_sel_n` in fall slots, `wr_sel_n` in rise slots, and `wr_data`/`wr_be_n` outside the four data cycles of an accepted write have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock at twice the main-clock rate |
| rst_n | input | 1 | Active-low synchronous reset |
| main_rise | output | 1 | High in a rise slot, low in a fall slot |
| rd_sel_n | input | 1 | Active-low read request, sampled in rise slots |
| wr_sel_n | input | 1 | Active-low write request, sampled in fall slots |
| addr | input | AW | Shared row address: read row in rise slots, write row in fall slots |
| wr_data | input | DW | Write word, one per cycle during a write burst |
| wr_be_n | input | LANES | Active-low byte-lane strobes for the current write word |
| rd_data | output | DW | Read word; held when not valid |
| rd_valid | output | 1 | High while a read word is on `rd_data` |

## Verification
The assertions assume that requests are placed relative to `main_rise` and that the read consumer never stalls, since `rd_valid` has no ready signal. The latency property also assumes that every rising edge of `rd_valid` comes from a request made while no burst was running. The stimulus is always aligned to a rise slot before each main cycle is driven, and it puts random values on the data and strobe pins outside write bursts. It places requests in the wrong slots, and requests while a burst is busy, only as deliberate probes that the bench expects to be ignored.

// File: rtl/b4s_pkg.sv
package b4s_pkg;
  localparam int BURST  = 4;
  localparam int LANE_W = 9;
  localparam int IDX_W  = $clog2(BURST);
  typedef logic [IDX_W-1:0] word_idx_t;
  localparam word_idx_t LAST_IDX = word_idx_t'(BURST - 1);
endpackage

// File: rtl/b4s_in_reg.sv
module b4s_in_reg #(
  parameter int AW    = 4,
  parameter int LANES = 2,
  localparam int DW   = LANES * b4s_pkg::LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_i,
  input  logic             rd_sel_n_i,
  input  logic             wr_sel_n_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [LANES-1:0] be_n_i,
  output logic             rd_req_o,
  output logic             wr_req_o,
  output logic [AW-1:0]    addr_o,
  output logic [DW-1:0]    wdata_o,
  output logic [LANES-1:0] lane_en_o
);
  logic             rise_q, rd_sel_n_q, wr_sel_n_q;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    wdata_q;
  logic [LANES-1:0] be_n_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rise_q     <= 1'b0;
      rd_sel_n_q <= 1'b1;
      wr_sel_n_q <= 1'b1;
      addr_q     <= '0;
      wdata_q    <= '0;
      be_n_q     <= '1;
    end else begin
      rise_q     <= rise_i;
      rd_sel_n_q <= rd_sel_n_i;
      wr_sel_n_q <= wr_sel_n_i;
      addr_q     <= addr_i;
      wdata_q    <= wdata_i;
      be_n_q     <= be_n_i;
    end
  end

  // read requests count only in rise slots, write requests only in fall slots
  assign rd_req_o  = !rd_sel_n_q && rise_q;
  assign wr_req_o  = !wr_sel_n_q && !rise_q;
  assign addr_o    = addr_q;
  assign wdata_o   = wdata_q;
  assign lane_en_o = ~be_n_q;
endmodule

// File: rtl/b4s_rd_seq.sv
module b4s_rd_seq
  import b4s_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic [AW-1:0] addr_i,
  output logic          fire_o,
  output word_idx_t     idx_o,
  output logic [AW-1:0] row_o
);
  logic          wait_q, busy_q;
  word_idx_t     idx_q;
  logic [AW-1:0] row_q;
  logic          accept;

  // a running burst is never cut; a new one may start on its last word
  assign accept = req_i && !wait_q && (!busy_q || idx_q == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wait_q <= 1'b0;
      busy_q <= 1'b0;
      idx_q  <= '0;
      row_q  <= '0;
    end else begin
      wait_q <= accept;
      if (accept) row_q <= addr_i;
      if (wait_q) begin
        busy_q <= 1'b1;
        idx_q  <= word_idx_t'(1);
      end else if (busy_q) begin
        idx_q <= word_idx_t'(idx_q + 1'b1);
        if (idx_q == LAST_IDX) busy_q <= 1'b0;
      end
    end
  end

  assign fire_o = wait_q || busy_q;
  assign idx_o  = wait_q ? '0 : idx_q;
  assign row_o  = row_q;
endmodule

// File: rtl/b4s_wr_seq.sv
module b4s_wr_seq
  import b4s_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic [AW-1:0]    addr_i,
  output logic [BURST-1:0] we_o,
  output logic [AW-1:0]    row_o
);
  logic          active_q;
  word_idx_t     idx_q;
  logic [AW-1:0] row_q;
  logic          accept;

  assign accept = req_i && (!active_q || idx_q == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      row_q    <= '0;
    end else if (accept) begin
      active_q <= 1'b1;
      idx_q    <= '0;
      row_q    <= addr_i;
    end else if (active_q) begin
      idx_q <= word_idx_t'(idx_q + 1'b1);
      if (idx_q == LAST_IDX) active_q <= 1'b0;
    end
  end

  always_comb begin
    for (int b = 0; b < BURST; b++)
      we_o[b] = active_q && (idx_q == word_idx_t'(b));
  end

  assign row_o = row_q;
endmodule

// File: rtl/b4s_bank.sv
module b4s_bank #(
  parameter int AW    = 4,
  parameter int LANES = 2,
  localparam int LW   = b4s_pkg::LANE_W,
  localparam int DW   = LANES * LW,
  localparam int ROWS = 1 << AW
) (
  input  logic             clk,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [LANES-1:0] lane_en_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [DW-1:0]    rdata_o
);
  logic [DW-1:0] mem_q [ROWS];

  always_ff @(posedge clk) begin
    if (we_i) begin
      for (int l = 0; l < LANES; l++)
        if (lane_en_i[l]) mem_q[waddr_i][l*LW +: LW] <= wdata_i[l*LW +: LW];
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/burst4_sram.sv
module burst4_sram
  import b4s_pkg::*;
#(
  parameter int AW    = 4,
  parameter int LANES = 2,
  localparam int DW   = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             main_rise,
  input  logic             rd_sel_n,
  input  logic             wr_sel_n,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [LANES-1:0] wr_be_n,
  output logic [DW-1:0]    rd_data,
  output logic             rd_valid
);
  logic             ph_q;
  logic             rd_req, wr_req;
  logic [AW-1:0]    addr_r;
  logic [DW-1:0]    wdata_r;
  logic [LANES-1:0] lane_en_r;
  logic             rd_fire;
  word_idx_t        rd_idx;
  logic [AW-1:0]    rd_row, wr_row;
  logic [BURST-1:0] wr_we;
  logic [DW-1:0]    bank_rd [BURST];
  logic [DW-1:0]    rd_data_q;
  logic             rd_valid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ph_q <= 1'b0;
    else        ph_q <= ~ph_q;
  end
  assign main_rise = ~ph_q;

  b4s_in_reg #(.AW(AW), .LANES(LANES)) u_in (
    .clk(clk), .rst_n(rst_n), .rise_i(main_rise),
    .rd_sel_n_i(rd_sel_n), .wr_sel_n_i(wr_sel_n), .addr_i(addr),
    .wdata_i(wr_data), .be_n_i(wr_be_n),
    .rd_req_o(rd_req), .wr_req_o(wr_req), .addr_o(addr_r),
    .wdata_o(wdata_r), .lane_en_o(lane_en_r)
  );

  b4s_rd_seq #(.AW(AW)) u_rd (
    .clk(clk), .rst_n(rst_n), .req_i(rd_req), .addr_i(addr_r),
    .fire_o(rd_fire), .idx_o(rd_idx), .row_o(rd_row)
  );

  b4s_wr_seq #(.AW(AW)) u_wr (
    .clk(clk), .rst_n(rst_n), .req_i(wr_req), .addr_i(addr_r),
    .we_o(wr_we), .row_o(wr_row)
  );

  for (genvar b = 0; b < BURST; b++) begin : g_bank
    b4s_bank #(.AW(AW), .LANES(LANES)) u_bank (
      .clk(clk), .we_i(wr_we[b]), .waddr_i(wr_row), .wdata_i(wdata_r),
      .lane_en_i(lane_en_r), .raddr_i(rd_row), .rdata_o(bank_rd[b])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= rd_fire;
      if (rd_fire) rd_data_q <= bank_rd[rd_idx];
    end
  end

  assign rd_data  = rd_data_q;
  assign rd_valid = rd_valid_q;
endmodule

// File: rtl/b4s_chk.sv
module b4s_chk #(
  parameter int DW = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          main_rise,
  input logic          rd_sel_n,
  input logic          rd_valid,
  input logic [DW-1:0] rd_data
);
  logic [b4s_pkg::IDX_W-1:0] vmod_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        vmod_q <= '0;
    else if (rd_valid) vmod_q <= vmod_q + 1'b1;
  end

  p_rise_then_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    main_rise |=> !main_rise);
  p_fall_then_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !main_rise |=> main_rise);
  p_first_word_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> $past(main_rise && !rd_sel_n, 3));
  p_whole_burst_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_valid) |-> (vmod_q == '0));
  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> $stable(rd_data));
endmodule

bind burst4_sram b4s_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .main_rise(main_rise), .rd_sel_n(rd_sel_n),
  .rd_valid(rd_valid), .rd_data(rd_data)
);

// File: tb/tb_burst4_sram.sv
`timescale 1ns/1ps
module tb_burst4_sram;
  localparam int AW = 4;
  localparam int LANES = 2;
  localparam int DW = 18;
  localparam int ROWS = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic main_rise;
  logic rd_sel_n = 1'b1, wr_sel_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [LANES-1:0] wr_be_n = '1;
  logic [DW-1:0] rd_data;
  logic rd_valid;

  always #2 clk = ~clk;

  burst4_sram #(.AW(AW), .LANES(LANES)) dut (
    .clk(clk), .rst_n(rst_n), .main_rise(main_rise), .rd_sel_n(rd_sel_n),
    .wr_sel_n(wr_sel_n), .addr(addr), .wr_data(wr_data), .wr_be_n(wr_be_n),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  int n_checks = 0, n_fail = 0, cyc = 0;
  bit mon_en = 0, done = 0;
  string cur_tag = "R2";

  logic [DW-1:0] model [ROWS*4];
  logic [DW-1:0] exp_q [$];
  int            expc_q [$];
  string         tag_q [$];

  logic [DW-1:0]    pw [4];
  logic [LANES-1:0] pbe [4];
  int  pcnt = 4;
  bit  rd_last = 0, wr_last = 0;
  logic [DW-1:0] last_q;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [DW-1:0] wword(input logic [DW-1:0] v, input int k);
    return v ^ DW'(k * 32'h2B47);
  endfunction

  task automatic drive_data();
    if (pcnt < 4) begin
      wr_data = pw[pcnt];
      wr_be_n = pbe[pcnt];
      pcnt++;
    end else begin
      wr_data = DW'($urandom);
      wr_be_n = LANES'($urandom);
    end
  endtask

  // one main cycle: rise slot then fall slot
  task automatic main_cyc(input bit rg, input logic [AW-1:0] ra, input bit wg,
                          input logic [AW-1:0] wa, input logic [DW-1:0] wv,
                          input logic [7:0] bem, input bit jr, input bit jw);
    @(negedge clk);
    while (!main_rise) @(negedge clk);
    rd_sel_n = !rg;
    wr_sel_n = !jw;
    addr = rg ? ra : wa;
    drive_data();
    if (rg && !rd_last) begin
      for (int k = 0; k < 4; k++) begin
        exp_q.push_back(model[ra*4 + k]);
        expc_q.push_back(cyc + 3 + k);
        tag_q.push_back(cur_tag);
      end
    end
    rd_last = rg && !rd_last;
    @(negedge clk);
    rd_sel_n = !jr;
    wr_sel_n = !wg;
    addr = wa;
    drive_data();
    if (wg && !wr_last) begin
      for (int k = 0; k < 4; k++) begin
        pw[k]  = wword(wv, k);
        pbe[k] = bem[2*k +: 2];
        for (int l = 0; l < LANES; l++)
          if (!pbe[k][l]) model[wa*4 + k][l*9 +: 9] = pw[k][l*9 +: 9];
      end
      pcnt = 0;
    end
    wr_last = wg && !wr_last;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) main_cyc(0, '0, 0, '0, '0, '0, 0, 0);
  endtask

  task automatic read_all(input string tag);
    cur_tag = tag;
    for (int r = 0; r < ROWS; r++) begin
      main_cyc(1, AW'(r), 0, '0, '0, '0, 0, 0);
      idle(1);
    end
    idle(4);
  endtask

  always @(negedge clk) begin
    if (rst_n && mon_en) begin
      if (rd_valid) begin
        if (exp_q.size() == 0) check(0, "R3 unexpected word", 32'(rd_data), 0);
        else begin
          logic [DW-1:0] e;
          int c;
          string t;
          e = exp_q.pop_front();
          c = expc_q.pop_front();
          t = tag_q.pop_front();
          check(rd_data == e, t, 32'(rd_data), 32'(e));
          check(c == cyc, "R2 word cycle", cyc, c);
        end
      end else begin
        check(rd_data == last_q, "R8 hold", 32'(rd_data), 32'(last_q));
        if (expc_q.size() > 0 && expc_q[0] <= cyc) begin
          check(0, {tag_q[0], " missing word"}, 0, 32'(exp_q[0]));
          void'(exp_q.pop_front());
          void'(expc_q.pop_front());
          void'(tag_q.pop_front());
        end
      end
      last_q = rd_data;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    check(rd_valid == 1'b0, "R1 valid in reset", 32'(rd_valid), 0);
    check(rd_data == '0, "R1 data in reset", 32'(rd_data), 0);
    check(main_rise == 1'b1, "R1 rise in reset", 32'(main_rise), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(main_rise == 1'b0, "R1 first slot", 32'(main_rise), 0);
    @(negedge clk);
    check(main_rise == 1'b1, "R1 second slot", 32'(main_rise), 1);
    last_q = rd_data;
    mon_en = 1;

    // R4: fill every row, all lanes enabled
    for (int r = 0; r < ROWS; r++) begin
      main_cyc(0, '0, 1, AW'(r), DW'(32'h1000 + r * 32'h3C5), 8'h00, 0, 0);
      idle(1);
    end
    idle(3);
    read_all("R4");

    // R2: back-to-back reads, seamless bursts, after rewriting rows
    cur_tag = "R2";
    for (int r = 0; r < ROWS; r++) begin
      main_cyc(1, AW'(r), 1, AW'(ROWS - 1 - r), DW'(32'h2A000 + r * 32'h91), 8'h00, 0, 0);
    end
    idle(4);
    read_all("R2");

    // R6: byte-lane masks, all lane patterns
    for (int r = 0; r < ROWS; r++) begin
      main_cyc(0, '0, 1, AW'(r), DW'(32'h15555 ^ r * 32'h777), 8'(r * 37 + 5), 0, 0);
      idle(1);
    end
    idle(3);
    read_all("R6");

    // R7: overlap ordering (write before read, read before write)
    cur_tag = "R7";
    main_cyc(0, '0, 1, 4'd5, 18'h0ABCD, 8'h00, 0, 0);
    main_cyc(1, 4'd5, 0, '0, '0, '0, 0, 0);
    idle(2);
    main_cyc(1, 4'd6, 1, 4'd6, 18'h3F00F, 8'h00, 0, 0);
    idle(1);
    main_cyc(1, 4'd6, 0, '0, '0, '0, 0, 0);
    idle(4);

    // R3: read in the slot after an accepted read is ignored
    cur_tag = "R3";
    main_cyc(1, 4'd1, 0, '0, '0, '0, 0, 0);
    main_cyc(1, 4'd2, 0, '0, '0, '0, 0, 0);
    main_cyc(1, 4'd3, 0, '0, '0, '0, 0, 0);
    idle(4);

    // R5: write in the slot after an accepted write is ignored
    main_cyc(0, '0, 1, 4'd8, 18'h12345, 8'h00, 0, 0);
    main_cyc(0, '0, 1, 4'd9, 18'h23456, 8'h00, 0, 0);
    idle(3);
    cur_tag = "R5";
    main_cyc(1, 4'd9, 0, '0, '0, '0, 0, 0);
    idle(1);
    main_cyc(1, 4'd8, 0, '0, '0, '0, 0, 0);
    idle(4);

    // R9: selects in the wrong slot and stray data are ignored
    cur_tag = "R9";
    for (int r = 0; r < 4; r++) begin
      main_cyc(0, '0, 0, AW'(r + 10), '0, '0, 1, 1);
      idle(1);
    end
    idle(3);
    for (int r = 0; r < 4; r++) begin
      main_cyc(1, AW'(r + 10), 0, '0, '0, '0, 0, 0);
      idle(1);
    end
    idle(4);

    // R7: mixed random traffic
    cur_tag = "R7";
    for (int i = 0; i < 300; i++) begin
      main_cyc(bit'($urandom % 2), AW'($urandom), bit'($urandom % 2), AW'($urandom),
               DW'($urandom), 8'($urandom), bit'(($urandom % 4) == 0), bit'(($urandom % 4) == 0));
    end
    idle(6);
    check(exp_q.size() == 0, "R2 all words delivered", exp_q.size(), 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule